// File: doc/BRIEF.md
# Program-store security bit guard

This block protects a 4 KB on-chip program store with one byte of security bits. The bits are active low and can only be lowered. A programming station reaches the byte at address FFFFh while the chip is in programming mode. The block decides whether each programmer read is granted, and whether each table-lookup read issued in run mode is granted. It picks the byte that goes back: an array byte, the security byte, or a fixed denial pattern. When scrambling is active, it XORs port data with a fixed key. It also drives the oscillator-gain select from one of the bits.

The flash array sits outside the block and supplies its byte on `arr_rdata`. The caller gives the address, the mode, and the strobes. The block answers combinationally in the same cycle. Writes to the security byte take effect at the next clock edge. The bits can go back to 1 only through the whole-chip erase strobe.

Top module: `secbit_guard`

## Requirements
- R1: After reset all security bits read as 1: `osc_full_gain` is 1, programmer reads are granted, and data is not scrambled.
- R2: Bits 6 to 3 of the security byte are reserved and stay 1, whatever value is programmed.
- R3: A program strobe in programming mode at address FFFFh clears each security bit whose written data bit is 0. A 1 in the written data leaves the bit unchanged, so no bit ever goes from 0 to 1 through programming.
- R4: An erase strobe in programming mode returns every security bit to 1 at the next edge. Erase wins over a program strobe in the same cycle.
- R5: In run mode (`prog_mode`=0) the program and erase strobes have no effect on the security byte.
- R6: A programmer read with the lock bit (bit 0) at 1 is granted. It returns the security byte at address FFFFh and the array byte at any other address.
- R7: When bit 0 is 0, every programmer read is denied: `access_ok` is 0 and the driven data is FFh. This holds for both array and security-byte addresses.
- R8: When bit 1 is 0, a run-mode table read with `tbl_from_ext`=1 and an address below 1000h is denied: `access_ok` is 0 and the data is FFh. Table reads from internal code, and table reads at 1000h or above, return the array byte.
- R9: When bit 2 is 0, every granted programmer read returns its byte XOR 5Ah. Run-mode table reads are never scrambled.
- R10: `osc_full_gain` equals bit 7: 1 selects full gain and 0 selects half gain.
- R11: During a programmer read with `out_en_n` high, `rd_drive` is 0 and `rd_data` is 00h.
- R12: With no read request in the current mode, `access_ok` is 0 and `rd_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_mode | input | 1 | 1 = programming mode, 0 = run mode |
| prg_read_stb | input | 1 | Programmer read request |
| prg_prog_stb | input | 1 | Programmer program strobe |
| prg_erase_stb | input | 1 | Whole-chip erase strobe |
| out_en_n | input | 1 | Output enable, active low; high floats the port |
| tbl_req | input | 1 | Run-mode table-lookup read request |
| tbl_from_ext | input | 1 | Table read issued from external code |
| addr | input | 16 | Access address |
| prg_wdata | input | 8 | Byte to program |
| arr_rdata | input | 8 | Byte from the program store at `addr` |
| access_ok | output | 1 | Current read request granted |
| rd_data | output | 8 | Returned byte |
| rd_drive | output | 1 | Port driver enable for programmer reads |
| osc_full_gain | output | 1 | 1 = full oscillator gain, 0 = half |

## Verification
The checker watches several rules on every cycle:
- the reserved bits staying high;
- the absence of any 0-to-1 change without erase;
- the all-ones result of erase;
- the frozen byte in run mode;
- denial under the lock and under the cross-region table rule;
- a quiet port when output is disabled or nothing is requested.

Some behaviour only the bench scenarios can show, because it depends on exact values built up over a sequence of writes. This covers the scrambled values, which byte comes back at FFFFh and at array addresses, the 1000h region boundary, the gain output following a cleared bit 7, and recovery after erase and after reset.

// File: rtl/secbit_pkg.sv
// Shared constants and types for the security bit guard.
// Assumes an 8-bit security byte with fixed bit roles.
package secbit_pkg;
    localparam int SEC_W    = 8;
    localparam int LOCK_BIT = 0;
    localparam int TBL_BIT  = 1;
    localparam int SCR_BIT  = 2;
    localparam int GAIN_BIT = 7;
    localparam logic [SEC_W-1:0] RSV_MASK = 8'h78;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_ARRAY,
        SRC_SECREG,
        SRC_DENY
    } rd_src_e;
endpackage

// File: rtl/secbit_store.sv
// Security byte storage. Bits only fall on program, rise on erase.
// Assumes reset models an erased part (all ones).
module secbit_store
    import secbit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             erase_en,
    input  logic [SEC_W-1:0] wr_data,
    output logic [SEC_W-1:0] sec_q
);
    // Update the byte: erase first, then one-way program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '1;
        end else if (erase_en) begin
            sec_q <= '1;
        end else if (wr_en) begin
            sec_q <= sec_q & (wr_data | RSV_MASK);
        end
    end
endmodule

// File: rtl/secbit_read_gate.sv
// Decides grant and data source for programmer and table reads.
// Assumes the internal region starts at address 0.
module secbit_read_gate
    import secbit_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int INT_BYTES = 4096
) (
    input  logic              prog_mode,
    input  logic              prg_read,
    input  logic              tbl_req,
    input  logic              tbl_from_ext,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEC_W-1:0]  sec_q,
    output logic              grant,
    output rd_src_e           src,
    output logic              scramble
);
    localparam logic [ADDR_W-1:0] SEC_ADDR = '1;
    localparam logic [ADDR_W:0]   INT_LIM  = (ADDR_W+1)'(INT_BYTES);

    logic in_internal;
    assign in_internal = ({1'b0, addr} < INT_LIM);

    // Select grant, source and scramble for the active request.
    always_comb begin
        grant    = 1'b0;
        src      = SRC_NONE;
        scramble = 1'b0;
        if (prog_mode && prg_read) begin
            if (!sec_q[LOCK_BIT]) begin
                src = SRC_DENY;
            end else begin
                grant    = 1'b1;
                src      = (addr == SEC_ADDR) ? SRC_SECREG : SRC_ARRAY;
                scramble = !sec_q[SCR_BIT];
            end
        end else if (!prog_mode && tbl_req) begin
            if (!sec_q[TBL_BIT] && tbl_from_ext && in_internal) begin
                src = SRC_DENY;
            end else begin
                grant = 1'b1;
                src   = SRC_ARRAY;
            end
        end
    end
endmodule

// File: rtl/secbit_scrambler.sv
// Bitwise XOR of the data with a fixed key when enabled.
// Assumes the key is a design constant.
module secbit_scrambler #(
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY  = 8'h5A
) (
    input  logic              enable,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // One XOR gate per data bit, gated by the key bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = din[i] ^ (enable & KEY[i]);
    end
endmodule

// File: rtl/secbit_guard.sv
// Top: guards program-store and security-byte reads, and programs the byte.
// Assumes the array supplies arr_rdata for addr in the same cycle.
module secbit_guard
    import secbit_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int INT_BYTES = 4096,
    parameter logic [SEC_W-1:0] SCR_KEY = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              prg_read_stb,
    input  logic              prg_prog_stb,
    input  logic              prg_erase_stb,
    input  logic              out_en_n,
    input  logic              tbl_req,
    input  logic              tbl_from_ext,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEC_W-1:0]  prg_wdata,
    input  logic [SEC_W-1:0]  arr_rdata,
    output logic              access_ok,
    output logic [SEC_W-1:0]  rd_data,
    output logic              rd_drive,
    output logic              osc_full_gain
);
    localparam logic [ADDR_W-1:0] SEC_ADDR = '1;

    logic [SEC_W-1:0] sec_q;
    logic [SEC_W-1:0] sel_data;
    logic [SEC_W-1:0] scr_data;
    logic             wr_en;
    logic             erase_en;
    logic             scramble;
    logic             floating;
    rd_src_e          src;

    assign wr_en    = prog_mode && prg_prog_stb && (addr == SEC_ADDR);
    assign erase_en = prog_mode && prg_erase_stb;

    secbit_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .erase_en (erase_en),
        .wr_data  (prg_wdata),
        .sec_q    (sec_q)
    );

    secbit_read_gate #(
        .ADDR_W    (ADDR_W),
        .INT_BYTES (INT_BYTES)
    ) u_gate (
        .prog_mode    (prog_mode),
        .prg_read     (prg_read_stb),
        .tbl_req      (tbl_req),
        .tbl_from_ext (tbl_from_ext),
        .addr         (addr),
        .sec_q        (sec_q),
        .grant        (access_ok),
        .src          (src),
        .scramble     (scramble)
    );

    assign sel_data = (src == SRC_SECREG) ? sec_q : arr_rdata;

    secbit_scrambler #(
        .DATA_W (SEC_W),
        .KEY    (SCR_KEY)
    ) u_scr (
        .enable (scramble),
        .din    (sel_data),
        .dout   (scr_data)
    );

    assign floating      = prog_mode && prg_read_stb && out_en_n;
    assign rd_drive      = prog_mode && prg_read_stb && !out_en_n;
    assign osc_full_gain = sec_q[GAIN_BIT];

    // Form the returned byte from the source decision.
    always_comb begin
        if (floating) begin
            rd_data = '0;
        end else begin
            case (src)
                SRC_NONE: rd_data = '0;
                SRC_DENY: rd_data = '1;
                default:  rd_data = scr_data;
            endcase
        end
    end
endmodule

// File: rtl/secbit_guard_chk.sv
// Checker for secbit_guard, attached with bind below.
// Assumes the top's internal security byte is named sec_q.
module secbit_guard_chk #(
    parameter int ADDR_W    = 16,
    parameter int INT_BYTES = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_mode,
    input logic              prg_read_stb,
    input logic              prg_erase_stb,
    input logic              out_en_n,
    input logic              tbl_req,
    input logic              tbl_from_ext,
    input logic [ADDR_W-1:0] addr,
    input logic              access_ok,
    input logic [7:0]        rd_data,
    input logic              rd_drive,
    input logic [7:0]        sec_q
);
    localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(INT_BYTES);

    logic low_region;
    assign low_region = ({1'b0, addr} < LIM);

    // R2: reserved bits are always high
    a_r2_reserved_high: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q[6:3] == 4'hF);

    // R3: no bit rises unless erase was applied
    a_r3_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_mode && prg_erase_stb) |=> ((sec_q & ~$past(sec_q)) == 8'h00));

    // R4: erase yields all ones
    a_r4_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode && prg_erase_stb) |=> (sec_q == 8'hFF));

    // R5: run mode leaves the byte alone
    a_r5_run_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode |=> $stable(sec_q));

    // R7: lock denies programmer reads
    a_r7_lock_denies: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode && prg_read_stb && !sec_q[0]) |-> !access_ok);

    // R8: cross-region table read denied with FFh
    a_r8_cross_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_mode && tbl_req && tbl_from_ext && low_region && !sec_q[1])
        |-> (!access_ok && rd_data == 8'hFF));

    // R11: floated port is quiet
    a_r11_float_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode && prg_read_stb && out_en_n) |-> (!rd_drive && rd_data == 8'h00));

    // R12: no request, no grant and zero data
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((prog_mode && !prg_read_stb) || (!prog_mode && !tbl_req))
        |-> (!access_ok && rd_data == 8'h00));
endmodule

bind secbit_guard secbit_guard_chk #(
    .ADDR_W    (ADDR_W),
    .INT_BYTES (INT_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_mode     (prog_mode),
    .prg_read_stb  (prg_read_stb),
    .prg_erase_stb (prg_erase_stb),
    .out_en_n      (out_en_n),
    .tbl_req       (tbl_req),
    .tbl_from_ext  (tbl_from_ext),
    .addr          (addr),
    .access_ok     (access_ok),
    .rd_data       (rd_data),
    .rd_drive      (rd_drive),
    .sec_q         (sec_q)
);

// File: tb/test_secbit_guard.sv
// Bench for secbit_guard: vector table walk, then directed tests.
module test_secbit_guard;
    localparam logic [2:0] OP_IDLE = 3'd0;
    localparam logic [2:0] OP_RD   = 3'd1;
    localparam logic [2:0] OP_PG   = 3'd2;
    localparam logic [2:0] OP_ER   = 3'd3;
    localparam logic [2:0] OP_TBL  = 3'd4;
    localparam logic [2:0] OP_EP   = 3'd5;

    typedef struct packed {
        logic        mode;
        logic [2:0]  op;
        logic        ext;
        logic        oen;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [7:0]  arr;
        logic        eok;
        logic        edrv;
        logic [7:0]  edata;
        logic        egain;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b1, OP_IDLE, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'd1 },  // R1 R12
        '{1'b1, OP_RD,   1'b0, 1'b0, 16'h0123, 8'h00, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b1, 4'd6 },  // R6
        '{1'b1, OP_RD,   1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1, 4'd6 },  // R6 R1
        '{1'b1, OP_RD,   1'b0, 1'b1, 16'h0010, 8'h00, 8'h77, 1'b1, 1'b0, 8'h00, 1'b1, 4'd11},  // R11
        '{1'b1, OP_PG,   1'b0, 1'b1, 16'hFFFF, 8'hFB, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'd3 },  // R3 -> FB
        '{1'b1, OP_RD,   1'b0, 1'b0, 16'h0200, 8'h00, 8'h3C, 1'b1, 1'b1, 8'h66, 1'b1, 4'd9 },  // R9
        '{1'b1, OP_RD,   1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 1'b1, 1'b1, 8'hA1, 1'b1, 4'd9 },  // R9
        '{1'b1, OP_PG,   1'b0, 1'b1, 16'hFFFF, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'd3 },  // R3 no set
        '{1'b1, OP_RD,   1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 1'b1, 1'b1, 8'hA1, 1'b1, 4'd3 },  // R3
        '{1'b1, OP_PG,   1'b0, 1'b1, 16'hFFFF, 8'h03, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'd2 },  // R2 -> 7B
        '{1'b1, OP_RD,   1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 1'b1, 1'b1, 8'h21, 1'b0, 4'd2 },  // R2 R10
        '{1'b1, OP_PG,   1'b0, 1'b1, 16'hFFFF, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd10},  // R10 -> 78
        '{1'b1, OP_RD,   1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFF, 1'b0, 4'd7 },  // R7
        '{1'b1, OP_RD,   1'b0, 1'b0, 16'h0005, 8'h00, 8'h12, 1'b0, 1'b1, 8'hFF, 1'b0, 4'd7 },  // R7
        '{1'b0, OP_TBL,  1'b1, 1'b0, 16'h0100, 8'h00, 8'h12, 1'b0, 1'b0, 8'hFF, 1'b0, 4'd8 },  // R8
        '{1'b0, OP_TBL,  1'b0, 1'b0, 16'h0100, 8'h00, 8'h12, 1'b1, 1'b0, 8'h12, 1'b0, 4'd8 },  // R8
        '{1'b0, OP_TBL,  1'b1, 1'b0, 16'h1000, 8'h00, 8'h34, 1'b1, 1'b0, 8'h34, 1'b0, 4'd8 },  // R8
        '{1'b0, OP_TBL,  1'b1, 1'b0, 16'h0FFF, 8'h00, 8'h34, 1'b0, 1'b0, 8'hFF, 1'b0, 4'd8 },  // R8
        '{1'b0, OP_ER,   1'b0, 1'b0, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5 },  // R5
        '{1'b1, OP_IDLE, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5 },  // R5 R12
        '{1'b1, OP_EP,   1'b0, 1'b1, 16'hFFFF, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd4 },  // R4
        '{1'b1, OP_RD,   1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1, 4'd4 },  // R4
        '{1'b1, OP_RD,   1'b0, 1'b0, 16'h0FFF, 8'h00, 8'h81, 1'b1, 1'b1, 8'h81, 1'b1, 4'd4 },  // R4
        '{1'b0, OP_TBL,  1'b1, 1'b0, 16'h0FFF, 8'h00, 8'h34, 1'b1, 1'b0, 8'h34, 1'b1, 4'd4 }   // R4
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        prog_mode, prg_read_stb, prg_prog_stb, prg_erase_stb;
    logic        out_en_n, tbl_req, tbl_from_ext;
    logic [15:0] addr;
    logic [7:0]  prg_wdata, arr_rdata;
    logic        access_ok, rd_drive, osc_full_gain;
    logic [7:0]  rd_data;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    secbit_guard i_secbit_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .prog_mode     (prog_mode),
        .prg_read_stb  (prg_read_stb),
        .prg_prog_stb  (prg_prog_stb),
        .prg_erase_stb (prg_erase_stb),
        .out_en_n      (out_en_n),
        .tbl_req       (tbl_req),
        .tbl_from_ext  (tbl_from_ext),
        .addr          (addr),
        .prg_wdata     (prg_wdata),
        .arr_rdata     (arr_rdata),
        .access_ok     (access_ok),
        .rd_data       (rd_data),
        .rd_drive      (rd_drive),
        .osc_full_gain (osc_full_gain)
    );

    task automatic drive(input logic m, input logic [2:0] op, input logic ext,
                         input logic oen, input logic [15:0] a,
                         input logic [7:0] wd, input logic [7:0] arr);
        prog_mode     = m;
        prg_read_stb  = (op == OP_RD);
        prg_prog_stb  = (op == OP_PG) || (op == OP_EP);
        prg_erase_stb = (op == OP_ER) || (op == OP_EP);
        tbl_req       = (op == OP_TBL);
        tbl_from_ext  = ext;
        out_en_n      = oen;
        addr          = a;
        prg_wdata     = wd;
        arr_rdata     = arr;
    endtask

    task automatic check(input int req, input logic eok, input logic edrv,
                         input logic [7:0] edata, input logic egain);
        n_checks++;
        if (access_ok !== eok || rd_drive !== edrv || rd_data !== edata
            || osc_full_gain !== egain) begin
            n_fail++;
            $display("FAIL R%0d: got ok=%b drv=%b data=%h gain=%b, expected ok=%b drv=%b data=%h gain=%b",
                     req, access_ok, rd_drive, rd_data, osc_full_gain,
                     eok, edrv, edata, egain);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, OP_IDLE, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive on the falling edge, sample before the rising edge.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].mode, VECS[i].op, VECS[i].ext, VECS[i].oen,
                  VECS[i].addr, VECS[i].wd, VECS[i].arr);
            #2;
            check(int'(VECS[i].req), VECS[i].eok, VECS[i].edrv,
                  VECS[i].edata, VECS[i].egain);
            @(negedge clk);
        end

        // R5: run-mode program strobe at FFFFh must not clear bits
        drive(1'b0, OP_PG, 1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00);
        @(negedge clk);
        drive(1'b1, OP_RD, 1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00);
        #2;
        check(5, 1'b1, 1'b1, 8'hFF, 1'b1);
        @(negedge clk);

        // R1: lock and lower gain, then reset restores the erased state
        drive(1'b1, OP_PG, 1'b0, 1'b1, 16'hFFFF, 8'h7E, 8'h00);
        @(negedge clk);
        drive(1'b1, OP_RD, 1'b0, 1'b0, 16'h0040, 8'h00, 8'h55);
        #2;
        check(7, 1'b0, 1'b1, 8'hFF, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b1, OP_IDLE, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, OP_RD, 1'b0, 1'b0, 16'h0040, 8'h00, 8'h55);
        #2;
        check(1, 1'b1, 1'b1, 8'h55, 1'b1);
        @(negedge clk);

        // R3: program at a non-FFFFh address leaves the byte alone
        drive(1'b1, OP_PG, 1'b0, 1'b1, 16'h0FFF, 8'h00, 8'h00);
        @(negedge clk);
        drive(1'b1, OP_RD, 1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00);
        #2;
        check(3, 1'b1, 1'b1, 8'hFF, 1'b1);
        @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule